// File: doc/BRIEF.md
# Host Register and Palette Access Port

This block is the slave side of a parallel microcontroller bus. It gives a host read and write access to a small control register file and to a colour lookup palette. The palette holds 256 entries, and each entry is three 8-bit values kept in three separate colour banks. A 2-bit subaddress picks one of four ports: a palette pointer, a palette data window, a control index and a control data window. Both pointers step forward on their own after each data access. The host therefore sets a pointer once and then streams a run of bytes.

A host access is one clock cycle with the chip select held low. The read/write level and the subaddress are sampled on that clock edge. Read data sits on the bus output during that same cycle, and the pointer moves at the closing edge. One palette entry takes three data accesses: first the first bank, then the second bank, then the third bank. The palette pointer only advances after the third. Alongside the host path, a separate pixel-side port looks up all three banks for a pixel index and gives the result one clock later.

Top module: `hpp_top`

## Requirements
- R1: While chip select is low, the subaddress picks the port: 00 is the palette pointer, 01 the palette data window, 10 the control index and 11 the control data window. Read/write at 1 means read and 0 means write. Reading either pointer port returns its current 8-bit value.
- R2: A write to the palette pointer loads the written byte into the pointer. It also returns the bank sequence to the first bank, even in the middle of an entry.
- R3: Palette data accesses, reads and writes alike, go to bank 0, bank 1 and bank 2 in turn. The palette pointer stays put after the accesses to bank 0 and bank 1. It increments, wrapping from FFh to 00h, after the access to bank 2.
- R4: Every control data access, read or write, increments the 8-bit control index, wrapping from FFh to 00h.
- R5: After reset both pointers are 00h. Control register 00h holds 5Ch, 05h holds 21h, 06h holds 52h, 07h holds 32h, 08h holds 64h and 09h holds 02h. Every other control register holds 00h.
- R6: Bits 1:0 of register 04h are read-only. They read the `live_status` input, and host writes to them are ignored. Bits 7:6 of registers 05h and 07h are read-only zero. All other bits of registers 00h to 09h and 0Ch to 0Eh store what the host writes.
- R7: Registers 0Ah, 0Bh and 0Fh are reserved. They read 00h and ignore writes.
- R8: Control indices 10h to FFh read 00h and ignore writes. Accesses to them still increment the index.
- R9: `hd_oe` is high only in a cycle where chip select is low and read/write is 1. `hd_out` is 00h whenever `hd_oe` is low.
- R10: One clock after `pix_idx` is presented, `pix_r`, `pix_g` and `pix_b` show that entry's bank 0, bank 1 and bank 2 bytes.
- R11: Cycles with chip select high change neither pointer, nor the bank sequence, nor any stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hcs_n | input | 1 | Host chip select, active low; one access per low cycle |
| hrw | input | 1 | 1 = read, 0 = write |
| hsub | input | 2 | Port subaddress |
| hd_in | input | 8 | Host write data |
| hd_out | output | 8 | Host read data |
| hd_oe | output | 1 | Drive enable for the host data bus |
| live_status | input | 2 | Status bits shown in register 04h bits 1:0 |
| pix_idx | input | 8 | Pixel-side palette index |
| pix_r | output | 8 | Bank 0 byte for the pixel index |
| pix_g | output | 8 | Bank 1 byte for the pixel index |
| pix_b | output | 8 | Bank 2 byte for the pixel index |

## Verification
The assertions check the following on every cycle:
- the bank step and the pointer increment after every palette data access;
- the pointer load and bank clear on a pointer write;
- the control index step;
- the output-enable rule;
- that the pointers hold while chip select is high;
- that the status bits show up on reads of register 04h.

Other behaviour needs the bench's scenarios. These are:
- the register reset values;
- the writable masks;
- the reserved and out-of-range zeros;
- the palette contents read back over the host window and over the pixel port for all 256 entries;
- the index wrap at FFh.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

    localparam int DATA_W     = 8;
    localparam int PTR_W      = 8;
    localparam int PAL_DEPTH  = 2 ** PTR_W;
    localparam int NUM_BANKS  = 3;
    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int CTRL_REGS  = 16;
    localparam int CTRL_W     = $clog2(CTRL_REGS);
    localparam int STATUS_W   = 2;
    localparam logic [CTRL_W-1:0] STATUS_IDX = CTRL_W'(4);

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic [1:0] {
        SUB_PAL_PTR   = 2'b00,
        SUB_PAL_DATA  = 2'b01,
        SUB_CTRL_PTR  = 2'b10,
        SUB_CTRL_DATA = 2'b11
    } sub_t;

    typedef struct packed {
        logic  valid;
        logic  rd;
        sub_t  sub;
        byte_t data;
    } host_acc_t;

    localparam bank_t LAST_BANK = BANK_W'(NUM_BANKS - 1);

    // Bits the host may store in each control register.
    function automatic byte_t ctrl_wmask(input logic [CTRL_W-1:0] i);
        case (i)
            4'h4:              return 8'hFC;
            4'h5, 4'h7:        return 8'h3F;
            4'hA, 4'hB, 4'hF:  return 8'h00;
            default:           return 8'hFF;
        endcase
    endfunction

    function automatic byte_t ctrl_reset(input logic [CTRL_W-1:0] i);
        case (i)
            4'h0:    return 8'h5C;
            4'h5:    return 8'h21;
            4'h6:    return 8'h52;
            4'h7:    return 8'h32;
            4'h8:    return 8'h64;
            4'h9:    return 8'h02;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bank_t next_bank(input bank_t b);
        return (b == LAST_BANK) ? '0 : b + 1'b1;
    endfunction

endpackage

// File: rtl/hpp_ptr_seq.sv
module hpp_ptr_seq
    import hpp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_acc_t acc,
    output ptr_t      pal_ptr,
    output bank_t     bank,
    output ptr_t      ctrl_ptr,
    output logic      pal_we,
    output logic      ctrl_we
);

    always_comb begin
        pal_we  = acc.valid && !acc.rd && (acc.sub == SUB_PAL_DATA);
        ctrl_we = acc.valid && !acc.rd && (acc.sub == SUB_CTRL_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pal_ptr  <= '0;
            bank     <= '0;
            ctrl_ptr <= '0;
        end else if (acc.valid) begin
            case (acc.sub)
                SUB_PAL_PTR: begin
                    if (!acc.rd) begin
                        pal_ptr <= acc.data;
                        bank    <= '0;
                    end
                end
                SUB_PAL_DATA: begin
                    bank <= next_bank(bank);
                    if (bank == LAST_BANK)
                        pal_ptr <= pal_ptr + 1'b1;
                end
                SUB_CTRL_PTR: begin
                    if (!acc.rd)
                        ctrl_ptr <= acc.data;
                end
                default: ctrl_ptr <= ctrl_ptr + 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/hpp_palette.sv
module hpp_palette
    import hpp_pkg::*;
(
    input  logic                              clk,
    input  logic                              we,
    input  bank_t                             bank,
    input  ptr_t                              addr,
    input  byte_t                             wdata,
    input  ptr_t                              pix_addr,
    output byte_t                             host_rdata,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]  pix_q
);

    logic [NUM_BANKS-1:0][DATA_W-1:0] host_rd;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        byte_t mem [PAL_DEPTH];

        always_ff @(posedge clk) begin
            if (we && bank == BANK_W'(b))
                mem[addr] <= wdata;
            pix_q[b] <= mem[pix_addr];
        end

        assign host_rd[b] = mem[addr];
    end

    always_comb begin
        host_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank == BANK_W'(b))
                host_rdata = host_rd[b];
    end

endmodule

// File: rtl/hpp_ctrl_regs.sv
module hpp_ctrl_regs
    import hpp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  ptr_t                idx,
    input  byte_t               wdata,
    input  logic [STATUS_W-1:0] status,
    output byte_t               rdata
);

    byte_t              regs [CTRL_REGS];
    logic               in_range;
    logic [CTRL_W-1:0]  lo;

    assign in_range = (idx[PTR_W-1:CTRL_W] == '0);
    assign lo       = idx[CTRL_W-1:0];

    for (genvar r = 0; r < CTRL_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[r] <= ctrl_reset(CTRL_W'(r));
            else if (we && in_range && lo == CTRL_W'(r))
                regs[r] <= wdata & ctrl_wmask(CTRL_W'(r));
        end
    end

    always_comb begin
        rdata = '0;
        if (in_range) begin
            rdata = regs[lo];
            if (lo == STATUS_IDX)
                rdata[STATUS_W-1:0] = status;
        end
    end

endmodule

// File: rtl/hpp_top.sv
module hpp_top
    import hpp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hcs_n,
    input  logic       hrw,
    input  logic [1:0] hsub,
    input  logic [7:0] hd_in,
    output logic [7:0] hd_out,
    output logic       hd_oe,
    input  logic [1:0] live_status,
    input  logic [7:0] pix_idx,
    output logic [7:0] pix_r,
    output logic [7:0] pix_g,
    output logic [7:0] pix_b
);

    host_acc_t acc;
    ptr_t      pal_ptr;
    ptr_t      ctrl_ptr;
    bank_t     bank_sel;
    logic      pal_we;
    logic      ctrl_we;
    byte_t     pal_rdata;
    byte_t     ctrl_rdata;
    logic [NUM_BANKS-1:0][DATA_W-1:0] pix_q;

    always_comb begin
        acc.valid = !hcs_n;
        acc.rd    = hrw;
        acc.sub   = sub_t'(hsub);
        acc.data  = hd_in;
    end

    hpp_ptr_seq u_seq (
        .clk(clk), .rst(rst), .acc(acc),
        .pal_ptr(pal_ptr), .bank(bank_sel), .ctrl_ptr(ctrl_ptr),
        .pal_we(pal_we), .ctrl_we(ctrl_we)
    );

    hpp_palette u_pal (
        .clk(clk), .we(pal_we), .bank(bank_sel), .addr(pal_ptr),
        .wdata(hd_in), .pix_addr(pix_idx),
        .host_rdata(pal_rdata), .pix_q(pix_q)
    );

    hpp_ctrl_regs u_regs (
        .clk(clk), .rst(rst), .we(ctrl_we), .idx(ctrl_ptr),
        .wdata(hd_in), .status(live_status), .rdata(ctrl_rdata)
    );

    assign hd_oe = acc.valid && acc.rd;

    always_comb begin
        hd_out = '0;
        if (hd_oe) begin
            case (acc.sub)
                SUB_PAL_PTR:  hd_out = pal_ptr;
                SUB_PAL_DATA: hd_out = pal_rdata;
                SUB_CTRL_PTR: hd_out = ctrl_ptr;
                default:      hd_out = ctrl_rdata;
            endcase
        end
    end

    assign pix_r = pix_q[0];
    assign pix_g = pix_q[1];
    assign pix_b = pix_q[2];

endmodule

// File: rtl/hpp_checker.sv
module hpp_checker (
    input logic       clk,
    input logic       rst,
    input logic       hcs_n,
    input logic       hrw,
    input logic [1:0] hsub,
    input logic [7:0] hd_in,
    input logic [7:0] hd_out,
    input logic       hd_oe,
    input logic [1:0] live_status,
    input logic [7:0] pal_ptr,
    input logic [1:0] bank_sel,
    input logic [7:0] ctrl_ptr
);

    logic pal_data_acc;
    logic ctrl_data_acc;
    assign pal_data_acc  = !hcs_n && hsub == 2'b01;
    assign ctrl_data_acc = !hcs_n && hsub == 2'b11;

    // R3: early banks step on with the pointer held
    assert_bank_step_R3: assert property (@(posedge clk) disable iff (rst)
        (pal_data_acc && bank_sel != 2'd2)
        |=> (bank_sel == $past(bank_sel) + 2'd1) && (pal_ptr == $past(pal_ptr)));

    // R3: the last bank wraps the sequence and advances the pointer
    assert_ptr_adv_R3: assert property (@(posedge clk) disable iff (rst)
        (pal_data_acc && bank_sel == 2'd2)
        |=> (bank_sel == 2'd0) && (pal_ptr == $past(pal_ptr) + 8'd1));

    // R3: the sequence never leaves the three banks
    assert_bank_range_R3: assert property (@(posedge clk) disable iff (rst)
        bank_sel != 2'd3);

    // R2: a pointer write loads the pointer and clears the bank
    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!hcs_n && !hrw && hsub == 2'b00)
        |=> (pal_ptr == $past(hd_in)) && (bank_sel == 2'd0));

    // R4: the control index steps on every control data access
    assert_idx_step_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_data_acc |=> ctrl_ptr == $past(ctrl_ptr) + 8'd1);

    // R9: no drive while deselected or during a write
    assert_oe_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (hcs_n || !hrw) |-> (!hd_oe && hd_out == 8'h00));

    // R9: a read cycle drives the bus
    assert_oe_read_R9: assert property (@(posedge clk) disable iff (rst)
        (!hcs_n && hrw) |-> hd_oe);

    // R11: an idle cycle leaves the pointers and the bank alone
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        hcs_n |=> $stable(pal_ptr) && $stable(ctrl_ptr) && $stable(bank_sel));

    // R6: a read of register 04h shows the live status bits
    assert_status_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_data_acc && hrw && ctrl_ptr == 8'h04)
        |-> hd_out[1:0] == live_status);

endmodule

bind hpp_top hpp_checker u_chk (
    .clk(clk), .rst(rst), .hcs_n(hcs_n), .hrw(hrw), .hsub(hsub),
    .hd_in(hd_in), .hd_out(hd_out), .hd_oe(hd_oe),
    .live_status(live_status), .pal_ptr(pal_ptr),
    .bank_sel(bank_sel), .ctrl_ptr(ctrl_ptr)
);

// File: tb/sim_hpp_top.sv
`timescale 1ns/1ps
module sim_hpp_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hcs_n = 1'b1;
    logic       hrw = 1'b0;
    logic [1:0] hsub = 2'b00;
    logic [7:0] hd_in = 8'h00;
    logic [7:0] hd_out;
    logic       hd_oe;
    logic [1:0] live_status = 2'b10;
    logic [7:0] pix_idx = 8'h00;
    logic [7:0] pix_r, pix_g, pix_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hpp_top u0 (
        .clk(clk), .rst(rst), .hcs_n(hcs_n), .hrw(hrw), .hsub(hsub),
        .hd_in(hd_in), .hd_out(hd_out), .hd_oe(hd_oe),
        .live_status(live_status), .pix_idx(pix_idx),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
    );

    function automatic logic [7:0] pat_r(input int i); return 8'(i) ^ 8'h5A; endfunction
    function automatic logic [7:0] pat_g(input int i); return 8'(i * 3);     endfunction
    function automatic logic [7:0] pat_b(input int i); return ~8'(i);        endfunction
    function automatic logic [7:0] pat_c(input int i); return 8'h A5 ^ 8'(i * 17); endfunction

    function automatic logic [7:0] exp_mask(input int i);
        if (i == 4) return 8'hFC;
        if (i == 5 || i == 7) return 8'h3F;
        if (i == 10 || i == 11 || i == 15) return 8'h00;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] exp_rst(input int i);
        case (i)
            0: return 8'h5C; 5: return 8'h21; 6: return 8'h52;
            7: return 8'h32; 8: return 8'h64; 9: return 8'h02;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, sample before the rising edge.
    task automatic bus(input logic [1:0] sub, input logic rw, input logic [7:0] din,
                       output logic [7:0] dout, output logic oe);
        @(negedge clk);
        hcs_n = 1'b0; hrw = rw; hsub = sub; hd_in = din;
        #1;
        dout = hd_out; oe = hd_oe;
        @(posedge clk);
        #1;
        hcs_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sub, input logic [7:0] din);
        logic [7:0] d; logic o;
        bus(sub, 1'b0, din, d, o);
    endtask

    task automatic rd(input logic [1:0] sub, output logic [7:0] dout);
        logic o;
        bus(sub, 1'b1, 8'h00, dout, o);
    endtask

    task automatic pix(input int i, output logic [7:0] r, g, b);
        @(negedge clk);
        pix_idx = 8'(i);
        @(posedge clk);
        #1;
        r = pix_r; g = pix_g; b = pix_b;
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, r, g, b;
        logic o;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R9: idle bus is not driven
        @(negedge clk);
        chk(!hd_oe && hd_out == 8'h00, "R9 idle", {hd_oe, hd_out}, 0);

        // R5: pointers after reset
        rd(2'b00, d); chk(d == 8'h00, "R5 pal ptr", d, 0);
        rd(2'b10, d); chk(d == 8'h00, "R5 ctrl idx", d, 0);

        // R5 R6 R7: reset contents of every register
        for (int i = 0; i < 16; i++) begin
            logic [7:0] e;
            e = exp_rst(i);
            if (i == 4) e[1:0] = live_status;
            rd(2'b11, d);
            chk(d == e, "R5 reset value", d, e);
        end
        // R4: index stepped once per access
        rd(2'b10, d); chk(d == 8'h10, "R4 idx step", d, 8'h10);

        // R8: out-of-range indices
        rd(2'b11, d); chk(d == 8'h00, "R8 read 10h", d, 0);
        wr(2'b10, 8'h80);
        wr(2'b11, 8'hEE);
        rd(2'b10, d); chk(d == 8'h81, "R8 idx step", d, 8'h81);
        wr(2'b10, 8'h80);
        rd(2'b11, d); chk(d == 8'h00, "R8 write ignored", d, 0);

        // R9: write cycle keeps the bus undriven, read cycle drives it
        bus(2'b10, 1'b0, 8'h00, d, o); chk(!o && d == 8'h00, "R9 write cycle", {o, d}, 0);
        bus(2'b10, 1'b1, 8'h00, d, o); chk(o, "R9 read cycle", o, 1);

        // R6 R7: write a pattern, read it back through the masks
        live_status = 2'b01;
        wr(2'b10, 8'h00);
        for (int i = 0; i < 16; i++) wr(2'b11, pat_c(i));
        wr(2'b10, 8'h00);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] e;
            e = pat_c(i) & exp_mask(i);
            if (i == 4) e[1:0] = live_status;
            rd(2'b11, d);
            chk(d == e, (i == 10 || i == 11 || i == 15) ? "R7 reserved" : "R6 mask", d, e);
        end

        // R4: index wraps from FFh
        wr(2'b10, 8'hFF);
        rd(2'b11, d);
        rd(2'b10, d); chk(d == 8'h00, "R4 wrap", d, 0);

        // R3: partial entry holds the pointer
        wr(2'b00, 8'h10);
        wr(2'b01, 8'h11);
        rd(2'b00, d); chk(d == 8'h10, "R3 hold bank0", d, 8'h10);
        wr(2'b01, 8'h22);
        rd(2'b00, d); chk(d == 8'h10, "R3 hold bank1", d, 8'h10);
        wr(2'b01, 8'h33);
        rd(2'b00, d); chk(d == 8'h11, "R3 advance", d, 8'h11);

        // R2: pointer write restarts at the first bank
        wr(2'b00, 8'h20);
        wr(2'b01, 8'h99);
        wr(2'b00, 8'h20);
        rd(2'b00, d); chk(d == 8'h20, "R2 ptr load", d, 8'h20);
        wr(2'b01, 8'hA1); wr(2'b01, 8'hB2); wr(2'b01, 8'hC3);
        pix(32, r, g, b);
        chk({r, g, b} == 24'hA1B2C3, "R2 bank restart", {r, g, b}, 24'hA1B2C3);
        pix(16, r, g, b);
        chk({r, g, b} == 24'h112233, "R10 entry 10h", {r, g, b}, 24'h112233);

        // R11: idle cycles with noise on the other inputs
        @(negedge clk);
        hrw = 1'b0; hsub = 2'b01; hd_in = 8'hFF;
        repeat (4) @(posedge clk);
        rd(2'b00, d); chk(d == 8'h21, "R11 ptr held", d, 8'h21);
        pix(32, r, g, b);
        chk({r, g, b} == 24'hA1B2C3, "R11 data held", {r, g, b}, 24'hA1B2C3);

        // R3 R1: fill all entries
        wr(2'b00, 8'h00);
        for (int i = 0; i < 256; i++) begin
            wr(2'b01, pat_r(i)); wr(2'b01, pat_g(i)); wr(2'b01, pat_b(i));
        end
        rd(2'b00, d); chk(d == 8'h00, "R3 pointer wrap", d, 0);

        // R1 R3: read back over the host window
        for (int i = 0; i < 256; i++) begin
            rd(2'b01, r); rd(2'b01, g); rd(2'b01, b);
            chk({r, g, b} == {pat_r(i), pat_g(i), pat_b(i)}, "R1 host readback",
                {r, g, b}, {pat_r(i), pat_g(i), pat_b(i)});
        end

        // R10: pixel port sweep
        for (int i = 255; i >= 0; i--) begin
            pix(i, r, g, b);
            chk({r, g, b} == {pat_r(i), pat_g(i), pat_b(i)}, "R10 pixel",
                {r, g, b}, {pat_r(i), pat_g(i), pat_b(i)});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule